// File: doc/BRIEF.md
# Four-Cycle Bus Transfer Sequencer

This block runs one external bus transfer at a time, and every transfer has the same fixed four-clock shape. A request is accepted while the block is idle. The block then latches the address, the direction, the destination and any write data. It drives the address for one full clock before it pulls a read or write strobe low, so the address lines have time to settle. The strobe stays low for two clocks and is released in the fourth. There is no handshake with the target and there are no wait states.

For a read, the block gives a single-clock capture enable to the register that takes the data. That register is either the instruction register (fetch) or the operand register (execute), and the pulse falls in the last clock of the strobe, while the strobe is still low. The block also pulses a program-counter step strobe in the first clock of every fetch. Writes have the same timing, and the write data is driven onto the bus for all four clocks. A done pulse marks the fourth clock. The next request is taken no earlier than the idle clock that follows it.

Top module: `bus_cycle_seq`

## Requirements
- R1: During reset and in every idle clock, rdN and wrN are 1, while busAddr, busWdata, dataOe, capInsn, capOperand, pcStep and done are all 0.
- R2: A request with reqValid=1 seen at a clock edge while idle starts a transfer in the next clock. busAddr equals the reqAddr latched at that edge for all four transfer clocks, whatever reqAddr does afterwards.
- R3: On a read (reqWrite=0), rdN is 0 in transfer clocks 2 and 3 and 1 in clocks 1 and 4. wrN stays 1 throughout.
- R4: On a write (reqWrite=1), wrN is 0 in transfer clocks 2 and 3 and 1 in clocks 1 and 4. dataOe is 1 and busWdata equals the latched reqWdata in all four clocks. rdN stays 1.
- R5: On a read, exactly one capture enable is 1, and only in transfer clock 3. It is capInsn when reqTarget=0 (instruction register) and capOperand when reqTarget=1 (operand register). A write raises neither.
- R6: pcStep is 1 only in transfer clock 1 of a read with reqTarget=0.
- R7: done is 1 only in transfer clock 4, so each transfer occupies exactly four clocks.
- R8: A request present during transfer clocks 1 to 4 is ignored. The clock after done is always idle, and a request is accepted at the end of that idle clock.
- R9: rdN and wrN are never 0 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Transfer request, sampled while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTarget | input | 1 | Read destination: 0 = instruction register, 1 = operand register |
| reqAddr | input | ADDR_W | Transfer address |
| reqWdata | input | DATA_W | Write data |
| busAddr | output | ADDR_W | Bus address, 0 when idle |
| busWdata | output | DATA_W | Bus write data, 0 unless writing |
| dataOe | output | 1 | Data bus drive enable |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| capInsn | output | 1 | Capture enable for the instruction register |
| capOperand | output | 1 | Capture enable for the operand register |
| pcStep | output | 1 | Program-counter update strobe in the first clock of a fetch |
| done | output | 1 | Fourth-clock completion pulse |

## Verification
Four rules are checked by the assertions on every clock:
- the two strobes never overlap;
- a falling strobe stays low for exactly two clocks;
- the address holds while a strobe is low;
- a capture enable, the program-counter step and done each keep their fixed place relative to the strobe.

Some behaviour can only be shown by the bench's scenarios. That covers which destination gets the capture for a given target, the exact address and write-data values, and that requests arriving mid-transfer are dropped. It also covers the compulsory idle clock between back-to-back transfers.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_CAPTURE,
    PH_RELEASE
  } phase_t;

  typedef struct packed {
    logic loadCmd;
    logic driveAddr;
    logic driveData;
    logic rdLow;
    logic wrLow;
    logic capInsn;
    logic capOperand;
    logic pcStep;
    logic done;
  } strobes_t;

  localparam logic TGT_INSN    = 1'b0;
  localparam logic TGT_OPERAND = 1'b1;

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     reqTarget,
  output strobes_t strobes
);

  phase_t phase;
  logic   isWrite;
  logic   isOperand;
  logic   busy;
  logic   inStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      isWrite   <= 1'b0;
      isOperand <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase     <= PH_SETUP;
            isWrite   <= reqWrite;
            isOperand <= (reqTarget == TGT_OPERAND);
          end
        end
        PH_SETUP:   phase <= PH_STROBE;
        PH_STROBE:  phase <= PH_CAPTURE;
        PH_CAPTURE: phase <= PH_RELEASE;
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (phase != PH_IDLE);
    inStrobe = (phase == PH_STROBE) || (phase == PH_CAPTURE);
    strobes            = '0;
    strobes.loadCmd    = (phase == PH_IDLE) && reqValid;
    strobes.driveAddr  = busy;
    strobes.driveData  = busy && isWrite;
    strobes.rdLow      = inStrobe && !isWrite;
    strobes.wrLow      = inStrobe && isWrite;
    strobes.capInsn    = (phase == PH_CAPTURE) && !isWrite && !isOperand;
    strobes.capOperand = (phase == PH_CAPTURE) && !isWrite && isOperand;
    strobes.pcStep     = (phase == PH_SETUP) && !isWrite && !isOperand;
    strobes.done       = (phase == PH_RELEASE);
  end

endmodule

// File: rtl/bus_seq_dpath.sv
module bus_seq_dpath
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              dataOe,
  output logic              rdN,
  output logic              wrN,
  output logic              capInsn,
  output logic              capOperand,
  output logic              pcStep,
  output logic              done
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.loadCmd) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
    end
  end

  always_comb begin
    busAddr    = strobes.driveAddr ? addrQ : '0;
    busWdata   = strobes.driveData ? dataQ : '0;
    dataOe     = strobes.driveData;
    rdN        = !strobes.rdLow;
    wrN        = !strobes.wrLow;
    capInsn    = strobes.capInsn;
    capOperand = strobes.capOperand;
    pcStep     = strobes.pcStep;
    done       = strobes.done;
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqTarget,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              dataOe,
  output logic              rdN,
  output logic              wrN,
  output logic              capInsn,
  output logic              capOperand,
  output logic              pcStep,
  output logic              done
);

  strobes_t strobes;

  bus_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqTarget (reqTarget),
    .strobes   (strobes)
  );

  bus_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .dataOe     (dataOe),
    .rdN        (rdN),
    .wrN        (wrN),
    .capInsn    (capInsn),
    .capOperand (capOperand),
    .pcStep     (pcStep),
    .done       (done)
  );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              dataOe,
  input logic              rdN,
  input logic              wrN,
  input logic              capInsn,
  input logic              capOperand,
  input logic              pcStep,
  input logic              done
);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  p_read_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |=> !rdN ##1 rdN);

  p_write_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |=> !wrN ##1 wrN);

  p_write_drives_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> dataOe);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> $stable(busAddr));

  p_capture_in_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (capInsn || capOperand) |-> (!rdN && $past(!rdN) && !(capInsn && capOperand)));

  p_pcstep_leads_r6: assert property (@(posedge clk) disable iff (!rstN)
    pcStep |=> !rdN);

  p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdN && wrN && $past(!rdN || !wrN)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && rdN && wrN && !dataOe));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .dataOe     (dataOe),
  .rdN        (rdN),
  .wrN        (wrN),
  .capInsn    (capInsn),
  .capOperand (capOperand),
  .pcStep     (pcStep),
  .done       (done)
);

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic              reqTarget = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic dataOe, rdN, wrN, capInsn, capOperand, pcStep, done;

  int checkCount = 0;
  int failCount = 0;

  bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic expStrobeLow(int ph);
    return (ph == 2) || (ph == 3);
  endfunction

  task automatic checkIdle(input string req);
    chk(req, "rdN idle", 64'(rdN), 64'd1);
    chk(req, "wrN idle", 64'(wrN), 64'd1);
    chk(req, "busAddr idle", 64'(busAddr), 64'd0);
    chk(req, "busWdata idle", 64'(busWdata), 64'd0);
    chk(req, "flags idle", 64'({dataOe, capInsn, capOperand, pcStep, done}), 64'd0);
  endtask

  task automatic checkPhase(input int ph, input logic wr, input logic tgt,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    chk("R2", $sformatf("busAddr ph%0d", ph), 64'(busAddr), 64'(a));
    chk(wr ? "R4" : "R3", $sformatf("rdN ph%0d", ph), 64'(rdN),
        64'(!(!wr && expStrobeLow(ph))));
    chk(wr ? "R4" : "R3", $sformatf("wrN ph%0d", ph), 64'(wrN),
        64'(!(wr && expStrobeLow(ph))));
    chk("R4", $sformatf("dataOe ph%0d", ph), 64'(dataOe), 64'(wr));
    chk("R4", $sformatf("busWdata ph%0d", ph), 64'(busWdata), wr ? 64'(d) : 64'd0);
    chk("R5", $sformatf("capInsn ph%0d", ph), 64'(capInsn), 64'(!wr && !tgt && ph == 3));
    chk("R5", $sformatf("capOperand ph%0d", ph), 64'(capOperand), 64'(!wr && tgt && ph == 3));
    chk("R6", $sformatf("pcStep ph%0d", ph), 64'(pcStep), 64'(!wr && !tgt && ph == 1));
    chk("R7", $sformatf("done ph%0d", ph), 64'(done), 64'(ph == 4));
    chk("R9", $sformatf("strobe overlap ph%0d", ph), 64'(!rdN && !wrN), 64'd0);
  endtask

  // Called in an idle clock (just after an edge); returns in the idle clock after done.
  task automatic doXfer(input logic wr, input logic tgt,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic noise);
    reqValid = 1'b1; reqWrite = wr; reqTarget = tgt; reqAddr = a; reqWdata = d;
    @(posedge clk); #1;
    for (int ph = 1; ph <= 4; ph++) begin
      if (noise) begin
        // R8: requests during the transfer must be ignored
        reqValid = 1'b1; reqWrite = ~wr; reqTarget = ~tgt;
        reqAddr = ~a; reqWdata = ~d;
      end else begin
        reqValid = 1'b0;
      end
      checkPhase(ph, wr, tgt, a, d);
      if (ph < 4) begin
        @(posedge clk); #1;
      end
    end
    reqValid = 1'b0;
    @(posedge clk); #1;
    checkIdle("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    reqValid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checkIdle("R1");
    rstN = 1'b1;
    reqValid = 1'b0;
    @(posedge clk); #1;
    checkIdle("R1");
    repeat (2) @(posedge clk);
    #1;
    checkIdle("R1");

    // directed corners: fetch, operand read, write, with and without noise
    doXfer(1'b0, 1'b0, 24'h000000, 32'h0, 1'b0);
    doXfer(1'b0, 1'b1, 24'hFFFFFF, 32'h0, 1'b1);
    doXfer(1'b1, 1'b0, 24'hA5A5A5, 32'hFFFFFFFF, 1'b1);
    doXfer(1'b1, 1'b1, 24'h5A5A5A, 32'h00000000, 1'b0);

    for (int i = 0; i < 200; i++) begin
      logic wr, tgt, nz;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      wr = 1'($urandom);
      tgt = 1'($urandom);
      nz = 1'($urandom);
      a = ADDR_W'($urandom);
      d = $urandom;
      doXfer(wr, tgt, a, d, nz);
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); #1;
        checkIdle("R1");
      end
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule